// File: doc/BRIEF.md
# Flash Interface Power-State Controller

This block decides, cycle by cycle, which power state a flash-style memory interface is in: active, automatic sleep, or standby. It watches the chip select, the output enable, the device reset pin, the address bus and a busy flag raised by the program/erase engine. From these it produces a standby flag, a sleep flag, an output-latch flag, a data-valid flag that tracks the wake-up delay, and the enable for the data pad drivers. The read data presented on the pads comes from a register that follows the array and freezes while the block sleeps.

Sleep depends only on the address. Once the address has stayed the same for a programmable number of clock edges, the block sleeps. The read data is then frozen and stays available. Any address change ends sleep and starts a short access delay. Standby is requested either by deselecting the chip or by pulling the device reset pin low. A deselect is ignored while a program or erase is still busy. Leaving standby starts a longer chip-select access delay before read data counts as valid again. The device reset pin wins over everything. Standby wins over sleep.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: With `dev_rst_n`=1, `ce_n`=1 and `busy`=0 sampled at a rising edge, `standby` is 1 after that edge.
- R2: With `dev_rst_n`=0 sampled at a rising edge, `standby` is 1 after that edge, even when `busy`=1. `dq_oe` is 0 in the same cycle that `dev_rst_n` is 0.
- R3: While `busy`=1 and `dev_rst_n`=1, a high `ce_n` does not produce standby. Standby follows at the first edge that samples `busy`=0.
- R4: `sleep` rises after the edge at which `addr` has equalled its previous sampled value for `STABLE_CYC` consecutive edges. This holds whatever `ce_n` and `oe_n` do, provided the standby condition of R1/R2 is absent.
- R5: An edge that samples an `addr` different from the previous sample clears `sleep` after that edge and restarts the stability count from zero.
- R6: `dq_out` shows `array_data` as sampled at the previous edge whenever `sleep` was 0 at that edge. While `sleep`=1, `out_latch_en` is 1 and `dq_out` holds its value.
- R7: After `standby` falls, `data_valid` stays 0 for exactly `CE_WAKE` cycles and then rises, as long as no address change intervenes.
- R8: Outside standby, an address change makes `data_valid` 0 for `ADDR_WAKE` cycles. If a longer countdown is already pending, the change does not shorten it: that countdown simply continues.
- R9: Standby overrides sleep. When the standby condition is sampled, `sleep` is 0 after that edge, even if the address has been stable.
- R10: While `rst_n`=0: `standby`=1, `sleep`=0, `out_latch_en`=0, `data_valid`=0, `dq_oe`=0 and `dq_out`=0.
- R11: `dq_oe` is 1 exactly when `dev_rst_n`=1, `ce_n`=0, `oe_n`=0 and `standby`=0. Otherwise the pads are high impedance, whatever the value of `oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| dev_rst_n | input | 1 | Device reset pin level, active low |
| busy | input | 1 | Program or erase in progress |
| addr | input | AW | Address bus |
| array_data | input | DW | Read data from the array |
| dq_out | output | DW | Data toward the pads |
| dq_oe | output | 1 | Pad driver enable (0 = high impedance) |
| standby | output | 1 | Standby state |
| sleep | output | 1 | Automatic sleep state |
| out_latch_en | output | 1 | Output data is frozen |
| data_valid | output | 1 | Wake-up delay has elapsed |

## Verification
The hardest case to reach from the ports is a deselect that arrives while `busy` is high and is then followed by an address change. Here the pending chip-select delay and the address delay overlap. The stimulus holds `ce_n` high under `busy`, drops `busy` to enter standby, and reselects the chip. It then moves the address one cycle later, so the longer countdown is still running when the shorter one would have started. A free-running data pattern on `array_data` makes a frozen output show up as a mismatch in every cycle of sleep.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE  = 2'd0,
    PM_SLEEP   = 2'd1,
    PM_STANDBY = 2'd2
  } pm_mode_e;
endpackage

// File: rtl/fpc_addr_watch.sv
module fpc_addr_watch #(
  parameter int AW         = 18,
  parameter int STABLE_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  output logic          addr_chg,
  output logic          stable_hit
);
  localparam int CW = $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STABLE_CYC);

  logic [AW-1:0] prev_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    addr_chg = (addr != prev_q);
    if (addr_chg)            cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    else                     cnt_d = cnt_q;
    stable_hit = (cnt_d == LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= addr;
      cnt_q  <= cnt_d;
    end
  end

  // R5: a change always clears the stability count
  a_r5_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    addr_chg |=> (cnt_q == '0));
endmodule

// File: rtl/fpc_wake_timer.sv
module fpc_wake_timer #(
  parameter int CE_WAKE   = 7,
  parameter int ADDR_WAKE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_standby,
  input  logic to_standby,
  input  logic addr_chg,
  output logic idle
);
  localparam int MAXW = (CE_WAKE > ADDR_WAKE) ? CE_WAKE : ADDR_WAKE;
  localparam int WW   = $clog2(MAXW + 1) + 1;
  localparam logic [WW-1:0] CE_V = WW'(CE_WAKE);
  localparam logic [WW-1:0] AD_V = WW'(ADDR_WAKE);

  logic [WW-1:0] wake_q, wake_d;

  always_comb begin
    if (in_standby || to_standby) wake_d = CE_V;
    else if (addr_chg)            wake_d = (wake_q > AD_V) ? wake_q - 1'b1 : AD_V;
    else if (wake_q != '0)        wake_d = wake_q - 1'b1;
    else                          wake_d = wake_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= CE_V;
    else        wake_q <= wake_d;
  end

  assign idle = (wake_q == '0);

  // R7: an undisturbed countdown drops by exactly one each cycle
  a_r7_steady_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_standby && !to_standby && !addr_chg && wake_q != '0)
    |=> (wake_q == $past(wake_q) - 1'b1));
  // R8: an address change never leaves less than the address delay pending
  a_r8_addr_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_standby && !to_standby && addr_chg) |=> (wake_q >= AD_V));
endmodule

// File: rtl/fpc_out_latch.sv
module fpc_out_latch #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int LW    = 8;
  localparam int LANES = (DW + LW - 1) / LW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LO = g * LW;
    localparam int HI = ((LO + LW) > DW) ? DW - 1 : LO + LW - 1;
    logic [HI-LO:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lane_q <= '0;
      else if (!hold) lane_q <= din[HI:LO];
    end
    assign dout[HI:LO] = lane_q;
  end

  // R6: frozen output while holding
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(dout));
endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl #(
  parameter int AW         = 18,
  parameter int DW         = 16,
  parameter int STABLE_CYC = 8,
  parameter int CE_WAKE    = 7,
  parameter int ADDR_WAKE  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          dev_rst_n,
  input  logic          busy,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          standby,
  output logic          sleep,
  output logic          out_latch_en,
  output logic          data_valid
);
  import fpc_pkg::*;

  pm_mode_e mode_q, mode_d;
  logic     addr_chg, stable_hit, wake_idle;

  fpc_addr_watch #(.AW(AW), .STABLE_CYC(STABLE_CYC)) i_addr_watch (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .addr_chg(addr_chg), .stable_hit(stable_hit));

  always_comb begin
    if (!dev_rst_n)        mode_d = PM_STANDBY;
    else if (ce_n && !busy) mode_d = PM_STANDBY;
    else if (stable_hit)   mode_d = PM_SLEEP;
    else                   mode_d = PM_ACTIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_STANDBY;
    else        mode_q <= mode_d;
  end

  fpc_wake_timer #(.CE_WAKE(CE_WAKE), .ADDR_WAKE(ADDR_WAKE)) i_wake (
    .clk(clk), .rst_n(rst_n),
    .in_standby(mode_q == PM_STANDBY), .to_standby(mode_d == PM_STANDBY),
    .addr_chg(addr_chg), .idle(wake_idle));

  fpc_out_latch #(.DW(DW)) i_latch (
    .clk(clk), .rst_n(rst_n), .hold(mode_q == PM_SLEEP),
    .din(array_data), .dout(dq_out));

  assign standby      = (mode_q == PM_STANDBY);
  assign sleep        = (mode_q == PM_SLEEP);
  assign out_latch_en = sleep;
  assign data_valid   = !standby && wake_idle;
  assign dq_oe        = dev_rst_n && !ce_n && !oe_n && !standby;

  // R1: plain deselect leads to standby
  a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rst_n && ce_n && !busy) |=> standby);
  // R2: reset pin forces standby regardless of busy
  a_r2_reset_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rst_n |=> standby);
  // R3: busy holds off standby
  a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rst_n && busy) |=> !standby);
  // R5: address change ends sleep
  a_r5_change_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != $past(addr)) |=> !sleep);
  // R7: leaving standby starts with data not yet valid
  if (CE_WAKE > 0) begin : g_wake_chk
    a_r7_not_valid_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(standby) |-> !data_valid);
  end
endmodule

// File: tb/test_flash_pwr_ctrl.sv
module test_flash_pwr_ctrl;
  localparam int AW = 18, DW = 16, ST = 8, CEW = 7, ADW = 4;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, dev_rst_n = 1, busy = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] array_data = 16'hACE1;
  logic [DW-1:0] dq_out;
  logic dq_oe, standby, sleep, out_latch_en, data_valid;

  int vectors = 0, errors = 0;
  bit done = 0;

  flash_pwr_ctrl #(.AW(AW), .DW(DW), .STABLE_CYC(ST), .CE_WAKE(CEW), .ADDR_WAKE(ADW))
    i_flash_pwr_ctrl (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .dev_rst_n(dev_rst_n), .busy(busy), .addr(addr), .array_data(array_data),
    .dq_out(dq_out), .dq_oe(dq_oe), .standby(standby), .sleep(sleep),
    .out_latch_en(out_latch_en), .data_valid(data_valid));

  always #5 clk = ~clk;

  // behavioural reference: 0 active, 1 sleep, 2 standby
  int m_mode, m_stab, m_wake;
  logic [AW-1:0] m_prev;
  logic [DW-1:0] m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 2; m_stab = 0; m_wake = CEW; m_prev = '0; m_data = '0;
    end else begin
      bit chg;
      int nmode;
      chg = (addr != m_prev);
      if (chg) m_stab = 0; else if (m_stab < ST) m_stab++;
      if (!dev_rst_n || (ce_n && !busy)) nmode = 2;
      else if (m_stab >= ST) nmode = 1;
      else nmode = 0;
      if (nmode == 2 || m_mode == 2) m_wake = CEW;
      else if (chg) m_wake = (m_wake > ADW) ? m_wake - 1 : ADW;
      else if (m_wake > 0) m_wake--;
      if (m_mode != 1) m_data = array_data;
      m_prev = addr;
      m_mode = nmode;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1", "standby", 32'(standby), 32'(m_mode == 2));
    chk("R4", "sleep", 32'(sleep), 32'(m_mode == 1));
    chk("R6", "out_latch_en", 32'(out_latch_en), 32'(m_mode == 1));
    chk("R6", "dq_out", 32'(dq_out), 32'(m_data));
    chk("R7", "data_valid", 32'(data_valid), 32'(m_mode != 2 && m_wake == 0));
    chk("R11", "dq_oe", 32'(dq_oe), 32'(dev_rst_n && !ce_n && !oe_n && m_mode != 2));
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare_all();
      array_data = {array_data[14:0], array_data[15] ^ array_data[13] ^ array_data[12] ^ array_data[10]};
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10", "standby", 32'(standby), 1);
    chk("R10", "sleep", 32'(sleep), 0);
    chk("R10", "data_valid", 32'(data_valid), 0);
    chk("R10", "dq_oe", 32'(dq_oe), 0);
    chk("R10", "dq_out", 32'(dq_out), 0);
    chk("R10", "out_latch_en", 32'(out_latch_en), 0);
    rst_n = 1;
    ce_n = 0; oe_n = 0; addr = 18'h00123;
    step(CEW + 2);
    chk("R7", "valid after select", 32'(data_valid), 1);

    // R4/R5: exact sleep entry after an address change
    addr = 18'h00456;
    step(ST);
    chk("R4", "not yet asleep", 32'(sleep), 0);
    step(1);
    chk("R4", "asleep", 32'(sleep), 1);
    // R4: strobes do not disturb sleep, data frozen (R6)
    oe_n = 1; step(3); oe_n = 0; step(3);
    chk("R4", "still asleep", 32'(sleep), 1);
    // R8: address change lowers data_valid for ADDR_WAKE cycles
    addr = 18'h00457;
    step(1);
    chk("R5", "woken", 32'(sleep), 0);
    step(ADW - 1);
    chk("R8", "valid still low", 32'(data_valid), 0);
    step(1);
    chk("R8", "valid back", 32'(data_valid), 1);

    // R3: deselect while busy
    busy = 1; ce_n = 1;
    step(6);
    chk("R3", "no standby while busy", 32'(standby), 0);
    chk("R11", "pads off when deselected", 32'(dq_oe), 0);
    busy = 0;
    step(1);
    chk("R3", "standby after busy", 32'(standby), 1);
    // R9: long stable address in standby never sleeps
    step(ST + 4);
    chk("R9", "standby over sleep", 32'(sleep), 0);
    // R8: reselect then address change while longer delay pending
    ce_n = 0;
    step(1);
    addr = 18'h3FFFF;
    step(CEW - 1);
    chk("R8", "pending delay kept", 32'(data_valid), 0);
    step(1);
    chk("R8", "pending delay ends", 32'(data_valid), 1);

    // R2: reset pin while busy
    busy = 1;
    step(2);
    dev_rst_n = 0;
    #1;
    chk("R2", "pads off at once", 32'(dq_oe), 0);
    step(1);
    chk("R2", "standby under busy", 32'(standby), 1);
    step(3);
    dev_rst_n = 1; busy = 0;
    step(CEW + 2);

    // R5: address toggling every other cycle never sleeps
    for (int k = 0; k < 20; k++) begin
      addr = addr ^ 18'h00010;
      step(2);
      chk("R5", "no sleep on moving address", 32'(sleep), 0);
    end
    step(ST + 3);
    // R1: plain deselect
    ce_n = 1;
    step(1);
    chk("R1", "plain deselect", 32'(standby), 1);
    oe_n = 0;
    chk("R11", "oe ignored in standby", 32'(dq_oe), 0);
    step(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule